// File: doc/BRIEF.md
# Banked File Register Address Resolver

This block sits between instruction decode and data memory in a small 8-bit core. It takes the register operand of the current instruction, either a full 8-bit file operand or a short 5-bit peripheral operand, and returns the 12-bit physical data-memory address for it. Small operands reach fixed special registers that no bank setting moves. Two windows are moved by the bank register: a peripheral window, steered by its low nibble, and the general-purpose RAM above 0x1F, steered by its high nibble. Two operand codes are indirect ports. They use an 8-bit pointer as the address.

Each indirect access can step its pointer afterwards, by one up or one down, as set by that pointer's 2-bit mode field. Address resolution is purely combinational. The pointer values come in from the register file, and the block returns them one clock later, stepped if an indirect access through that pointer was strobed. Otherwise they come back unchanged.

Top module: `bank_addr_resolver`

## Requirements
- R1: For a file operand from 0x01 to 0x0F, other than 0x08, the address is the operand itself, with bits 11:8 zero, whatever the bank register holds.
- R2: For a file operand from 0x10 to 0x17, address bits 11:8 equal bank register bits 3:0 and address bits 7:0 equal the operand.
- R3: File operands 0x18 and 0x19 are never moved by the bank register. The address is the operand, with bits 11:8 zero.
- R4: File operands 0x1A to 0x1F map to their own address, with bits 11:8 zero.
- R5: For a file operand from 0x20 to 0xFF, address bits 11:8 equal bank register bits 7:4 and address bits 7:0 equal the operand.
- R6: Operand 0x00 gives the address {4'h0, pointer 0}. Operand 0x08 gives {4'h0, pointer 1}.
- R7: After a strobed indirect access through a pointer, its output is the input plus one (modulo 256) when its mode is 2'b01, minus one (modulo 256) when its mode is 2'b00, and unchanged when its mode is 2'b10 or 2'b11.
- R8: A pointer is not stepped when the strobe is low, or when the operand selects the other pointer or no pointer. Its output then equals its input.
- R9: When operand-kind is 1 (peripheral), only operand bits 4:0 are used. Bits 7:5 are ignored, and the map of R1 to R6 applies to the 5-bit value.
- R10: A synchronous active-high reset drives both pointer outputs to zero on the next clock edge.
- R11: The pointer outputs are registered. Each shows the value resulting from the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| access_en | input | 1 | Access strobe; enables pointer stepping |
| opnd_kind | input | 1 | 0: 8-bit file operand, 1: 5-bit peripheral operand |
| opnd | input | 8 | Operand field (peripheral form uses bits 4:0) |
| bank_sel | input | 8 | Bank register: bits 3:0 peripheral window, bits 7:4 RAM window |
| ptr0_in | input | 8 | Current value of indirect pointer 0 |
| ptr0_mode | input | 2 | Step mode of pointer 0 |
| ptr1_in | input | 8 | Current value of indirect pointer 1 |
| ptr1_mode | input | 2 | Step mode of pointer 1 |
| addr | output | 12 | Resolved physical address |
| ptr0_out | output | 8 | Registered updated pointer 0 |
| ptr1_out | output | 8 | Registered updated pointer 1 |

## Verification
The bench builds the block with its default widths: an 8-bit operand, an 8-bit bank register split into two nibbles, and 8-bit pointers. With these widths every operand code can be swept in both operand kinds, under random bank and pointer values. The 8-bit pointer size puts both wrap ends, 0xFF up to 0x00 and 0x00 down to 0xFF, within reach of directed steps. Random cycles then mix strobe, mode and pointer selection against a behavioural model, and reset is pulsed mid-run.

// File: rtl/fra_pkg.sv
package fra_pkg;

    localparam int OPND_W_DEF = 8;
    localparam int PER_W_DEF  = 5;
    localparam int BANK_W_DEF = 8;
    localparam int PTR_W_DEF  = 8;
    localparam int MODE_W     = 2;

    localparam logic [MODE_W-1:0] MODE_DOWN = 2'b00;
    localparam logic [MODE_W-1:0] MODE_UP   = 2'b01;

    typedef enum logic [2:0] {
        RG_SPECIAL,
        RG_PERIPH_BANKED,
        RG_PRODUCT,
        RG_RAM_FIXED,
        RG_RAM_BANKED,
        RG_PTR0,
        RG_PTR1
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [31:0] eff;
    } decode_t;

    // Region of an operand value that has been zero-extended to 32 bits
    function automatic region_e classify(input logic [31:0] op);
        if (op == 32'd0)       return RG_PTR0;
        else if (op == 32'd8)  return RG_PTR1;
        else if (op < 32'd16)  return RG_SPECIAL;
        else if (op < 32'd24)  return RG_PERIPH_BANKED;
        else if (op < 32'd26)  return RG_PRODUCT;
        else if (op < 32'd32)  return RG_RAM_FIXED;
        else                   return RG_RAM_BANKED;
    endfunction

endpackage

// File: rtl/fra_region_decode.sv
module fra_region_decode
    import fra_pkg::*;
#(
    parameter int OPND_W = OPND_W_DEF,
    parameter int PER_W  = PER_W_DEF
) (
    input  logic              kind,
    input  logic [OPND_W-1:0] raw,
    output decode_t           dec
);
    logic [OPND_W-1:0] eff_op;

    always_comb begin
        if (kind)
            eff_op = OPND_W'(raw[PER_W-1:0]);
        else
            eff_op = raw;
        dec.eff    = 32'(eff_op);
        dec.region = classify(32'(eff_op));
    end
endmodule

// File: rtl/fra_addr_build.sv
module fra_addr_build
    import fra_pkg::*;
#(
    parameter int OPND_W = OPND_W_DEF,
    parameter int BANK_W = BANK_W_DEF,
    parameter int PTR_W  = PTR_W_DEF,
    localparam int NIB_W  = BANK_W / 2,
    localparam int ADDR_W = OPND_W + NIB_W
) (
    input  decode_t           dec,
    input  logic [BANK_W-1:0] bank,
    input  logic [PTR_W-1:0]  ptr0,
    input  logic [PTR_W-1:0]  ptr1,
    output logic [ADDR_W-1:0] addr
);
    logic [OPND_W-1:0] op;
    assign op = dec.eff[OPND_W-1:0];

    always_comb begin
        unique case (dec.region)
            RG_PTR0:          addr = ADDR_W'(ptr0);
            RG_PTR1:          addr = ADDR_W'(ptr1);
            RG_PERIPH_BANKED: addr = {bank[NIB_W-1:0], op};
            RG_RAM_BANKED:    addr = {bank[BANK_W-1:NIB_W], op};
            default:          addr = ADDR_W'(op);
        endcase
    end
endmodule

// File: rtl/fra_ptr_unit.sv
module fra_ptr_unit
    import fra_pkg::*;
#(
    parameter int PTR_W = PTR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [PTR_W-1:0]  ptr_in,
    input  logic [MODE_W-1:0] mode,
    output logic [PTR_W-1:0]  ptr_out
);
    logic [PTR_W-1:0] stepped;

    always_comb begin
        unique case (mode)
            MODE_UP:   stepped = ptr_in + PTR_W'(1);
            MODE_DOWN: stepped = ptr_in - PTR_W'(1);
            default:   stepped = ptr_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_out <= '0;
        else if (hit)
            ptr_out <= stepped;
        else
            ptr_out <= ptr_in;
    end

    // R7: stepping by mode, wrap included
    p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == MODE_UP) |=> ptr_out == PTR_W'($past(ptr_in) + PTR_W'(1)));
    p_step_down_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == MODE_DOWN) |=> ptr_out == PTR_W'($past(ptr_in) - PTR_W'(1)));
    p_step_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && mode[1]) |=> ptr_out == $past(ptr_in));
    // R8 and R11: no hit, value passes through one cycle later
    p_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
        !hit |=> ptr_out == $past(ptr_in));
    // R10: reset clears the pointer
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> ptr_out == '0);
endmodule

// File: rtl/bank_addr_resolver.sv
module bank_addr_resolver
    import fra_pkg::*;
#(
    parameter int OPND_W = OPND_W_DEF,
    parameter int PER_W  = PER_W_DEF,
    parameter int BANK_W = BANK_W_DEF,
    parameter int PTR_W  = PTR_W_DEF,
    localparam int NIB_W  = BANK_W / 2,
    localparam int ADDR_W = OPND_W + NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access_en,
    input  logic              opnd_kind,
    input  logic [OPND_W-1:0] opnd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  ptr0_in,
    input  logic [MODE_W-1:0] ptr0_mode,
    input  logic [PTR_W-1:0]  ptr1_in,
    input  logic [MODE_W-1:0] ptr1_mode,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  ptr0_out,
    output logic [PTR_W-1:0]  ptr1_out
);
    localparam int NPTR = 2;

    decode_t dec;

    fra_region_decode #(.OPND_W(OPND_W), .PER_W(PER_W)) u_decode (
        .kind (opnd_kind),
        .raw  (opnd),
        .dec  (dec)
    );

    fra_addr_build #(.OPND_W(OPND_W), .BANK_W(BANK_W), .PTR_W(PTR_W)) u_addr (
        .dec  (dec),
        .bank (bank_sel),
        .ptr0 (ptr0_in),
        .ptr1 (ptr1_in),
        .addr (addr)
    );

    logic [PTR_W-1:0]  p_in  [NPTR];
    logic [PTR_W-1:0]  p_out [NPTR];
    logic [MODE_W-1:0] p_mode[NPTR];

    assign p_in[0]   = ptr0_in;
    assign p_in[1]   = ptr1_in;
    assign p_mode[0] = ptr0_mode;
    assign p_mode[1] = ptr1_mode;
    assign ptr0_out  = p_out[0];
    assign ptr1_out  = p_out[1];

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        localparam region_e MY_RG = (g == 0) ? RG_PTR0 : RG_PTR1;
        logic hit;
        assign hit = access_en && (dec.region == MY_RG);

        fra_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
            .clk     (clk),
            .rst     (rst),
            .hit     (hit),
            .ptr_in  (p_in[g]),
            .mode    (p_mode[g]),
            .ptr_out (p_out[g])
        );
    end

    // R1: low special registers ignore the bank register
    p_special_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && opnd != 0 && opnd != 8 && opnd < 16) |-> addr == ADDR_W'(opnd));
    // R2: peripheral window follows the low bank nibble
    p_periph_bank_r2: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && opnd >= 16 && opnd < 24) |->
        (addr[ADDR_W-1:OPND_W] == bank_sel[NIB_W-1:0] && addr[OPND_W-1:0] == opnd));
    // R3: product registers are never remapped
    p_product_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && (opnd == 24 || opnd == 25)) |-> addr == ADDR_W'(opnd));
    // R5: RAM window follows the high bank nibble
    p_ram_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && opnd >= 32) |->
        (addr[ADDR_W-1:OPND_W] == bank_sel[BANK_W-1:NIB_W] && addr[OPND_W-1:0] == opnd));
    // R6: indirect ports use the pointer value
    p_indirect0_r6: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && opnd == 0) |-> addr == ADDR_W'(ptr0_in));
    p_indirect1_r6: assert property (@(posedge clk) disable iff (rst)
        (!opnd_kind && opnd == 8) |-> addr == ADDR_W'(ptr1_in));
    // R9: peripheral operands at 0x18..0x1F map flat, whatever the upper bits
    p_periph_top_r9: assert property (@(posedge clk) disable iff (rst)
        (opnd_kind && opnd[PER_W-1 -: 2] == 2'b11) |-> addr == ADDR_W'(opnd[PER_W-1:0]));
endmodule

// File: tb/bank_addr_resolver_tb_top.sv
module bank_addr_resolver_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       access_en;
    logic       opnd_kind;
    logic [7:0] opnd;
    logic [7:0] bank_sel;
    logic [7:0] ptr0_in, ptr1_in;
    logic [1:0] ptr0_mode, ptr1_mode;
    logic [11:0] addr;
    logic [7:0] ptr0_out, ptr1_out;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    bank_addr_resolver dut_i (
        .clk(clk), .rst(rst), .access_en(access_en), .opnd_kind(opnd_kind),
        .opnd(opnd), .bank_sel(bank_sel), .ptr0_in(ptr0_in), .ptr0_mode(ptr0_mode),
        .ptr1_in(ptr1_in), .ptr1_mode(ptr1_mode), .addr(addr),
        .ptr0_out(ptr0_out), .ptr1_out(ptr1_out)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_addr(int o, int bank, int p0, int p1);
        if (o == 0) return p0;
        if (o == 8) return p1;
        if (o < 16) return o;
        if (o < 24) return (bank % 16) * 256 + o;
        if (o < 32) return o;
        return (bank / 16) * 256 + o;
    endfunction

    function automatic string addr_tag(bit kind, int o);
        if (kind) return "R9";
        if (o == 0 || o == 8) return "R6";
        if (o < 16) return "R1";
        if (o < 24) return "R2";
        if (o < 26) return "R3";
        if (o < 32) return "R4";
        return "R5";
    endfunction

    function automatic int ref_step(int p, int m, bit hit);
        if (!hit) return p;
        if (m == 1) return (p + 1) % 256;
        if (m == 0) return (p + 255) % 256;
        return p;
    endfunction

    task automatic drive(bit kind, int op, int bank, int p0, int m0,
                         int p1, int m1, bit acc, bit rr);
        int eo, e0, e1;
        string t0, t1;
        @(negedge clk);
        rst = rr; access_en = acc; opnd_kind = kind; opnd = op[7:0];
        bank_sel = bank[7:0]; ptr0_in = p0[7:0]; ptr0_mode = m0[1:0];
        ptr1_in = p1[7:0]; ptr1_mode = m1[1:0];
        #5;
        eo = kind ? (op % 32) : op;
        chk(addr_tag(kind, eo), int'(addr), ref_addr(eo, bank, p0, p1));
        e0 = rr ? 0 : ref_step(p0, m0, acc && eo == 0);
        e1 = rr ? 0 : ref_step(p1, m1, acc && eo == 8);
        t0 = rr ? "R10" : ((acc && eo == 0) ? "R7" : (acc ? "R8" : "R11"));
        t1 = rr ? "R10" : ((acc && eo == 8) ? "R7" : (acc ? "R8" : "R11"));
        @(posedge clk);
        #2;
        chk(t0, int'(ptr0_out), e0);
        chk(t1, int'(ptr1_out), e1);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; access_en = 1'b0; opnd_kind = 1'b0; opnd = '0; bank_sel = '0;
        ptr0_in = '0; ptr1_in = '0; ptr0_mode = '0; ptr1_mode = '0;
        repeat (2) @(posedge clk);
        #2;
        chk("R10", int'(ptr0_out), 0);
        chk("R10", int'(ptr1_out), 0);
        // reset wins over a strobed indirect access
        drive(0, 0, 8'h3C, 8'h55, 1, 8'h66, 1, 1, 1);
        // R7 wrap cases and hold modes
        drive(0, 0, 8'hA5, 8'hFF, 1, 8'h10, 1, 1, 0);
        drive(0, 0, 8'hA5, 8'h00, 0, 8'h10, 0, 1, 0);
        drive(0, 8, 8'hA5, 8'h20, 1, 8'hFF, 1, 1, 0);
        drive(0, 8, 8'hA5, 8'h20, 1, 8'h00, 0, 1, 0);
        drive(0, 0, 8'h00, 8'h41, 2, 8'h42, 3, 1, 0);
        drive(0, 8, 8'h00, 8'h41, 2, 8'h42, 3, 1, 0);
        // R8: no strobe, or other pointer selected
        drive(0, 0, 8'h12, 8'h77, 1, 8'h88, 0, 0, 0);
        drive(0, 8, 8'h12, 8'h77, 1, 8'h88, 0, 0, 0);
        drive(0, 8'h25, 8'h12, 8'h77, 1, 8'h88, 0, 1, 0);
        // R9: upper bits ignored in peripheral form
        drive(1, 8'hE0, 8'hFF, 8'h31, 1, 8'h32, 1, 1, 0);
        drive(1, 8'hA8, 8'hFF, 8'h31, 0, 8'h32, 0, 1, 0);
        drive(1, 8'hF3, 8'h9C, 8'h31, 0, 8'h32, 0, 1, 0);
        // R3: product registers with every bank bit set
        drive(0, 8'h18, 8'hFF, 0, 2, 0, 2, 1, 0);
        drive(0, 8'h19, 8'hFF, 0, 2, 0, 2, 1, 0);
        // full operand sweep in both kinds
        for (int k = 0; k < 2; k++) begin
            for (int op = 0; op < 256; op++) begin
                drive(k[0], op, $urandom % 256, $urandom % 256, $urandom % 4,
                      $urandom % 256, $urandom % 4, ($urandom % 4) != 0, 0);
            end
        end
        // mid-run reset pulse then recovery
        drive(0, 0, 8'h11, 8'hC0, 1, 8'hC1, 0, 1, 1);
        drive(0, 0, 8'h11, 8'hC0, 1, 8'hC1, 0, 1, 0);
        // random mix, biased to the indirect codes
        for (int n = 0; n < 1500; n++) begin
            int sel, op;
            sel = $urandom % 4;
            op = (sel == 0) ? 0 : (sel == 1) ? 8 : ($urandom % 256);
            drive($urandom % 2, op, $urandom % 256, $urandom % 256, $urandom % 4,
                  $urandom % 256, $urandom % 4, ($urandom % 3) != 0, ($urandom % 50) == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule